// File: doc/BRIEF.md
# Barrel Shift Execution Unit

This unit runs the shift operations of a 32-bit RISC pipeline. It receives one instruction word and the values of the two source operands. From the word it decodes the shift direction and where the shift amount comes from. It then produces the shifted word in a single cycle. Register-file access, hazard handling and writeback are done outside the unit. The operand values arrive on the ports directly.

The instruction word uses big-endian numbering: word bit 0 is the most significant, so word bit k is vector bit `instr[31-k]`. Two opcodes are recognised:
- The register form takes its shift amount from the low five bits of the second operand.
- The immediate form takes its shift amount from the last five bits of the word.

The shift kind is chosen from a fixed pattern in the low part of the word. Any other word raises an illegal flag and returns zero. The result, the valid pulse and the illegal flag are registered and appear one clock after the start strobe.

Top module: `bshift_unit`

## Requirements
- R1: While reset is asserted, and until the first start after reset, `resultValid` and `illegal` are low and `result` is zero.
- R2: A start sampled at a rising edge makes `resultValid` high for exactly the following clock cycle. Without a start in the previous cycle, `resultValid` is low.
- R3: Register form is `instr[31:26]` = 6'b010001. Here `instr[10:0]` = 11'h000 selects logical right, 11'h200 selects arithmetic right and 11'h400 selects left. The shift amount is `opB[4:0]`, and `opB[31:5]` has no effect.
- R4: Immediate form is `instr[31:26]` = 6'b011001. Here `instr[15:5]` = 11'h000 selects logical right, 11'h010 selects arithmetic right and 11'h020 selects left. The shift amount is `instr[4:0]`, and `opB` has no effect.
- R5: Logical right shift moves `opA` toward bit 0 and fills the vacated upper bits with zeros.
- R6: Arithmetic right shift moves `opA` toward bit 0 and fills the vacated upper bits with `opA[31]`.
- R7: Left shift moves `opA` toward bit 31 and fills the vacated lower bits with zeros.
- R8: A shift amount of zero returns `opA` unchanged in all three kinds.
- R9: Any other opcode, or any other pattern in the function field, gives `illegal` high together with `resultValid`, and `result` zero.
- R10: The destination and source register-number fields `instr[25:16]` have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Execute the presented instruction this cycle |
| instr | input | 32 | Instruction word (word bit 0 = instr[31]) |
| opA | input | 32 | Value shifted |
| opB | input | 32 | Register-form shift amount source |
| result | output | 32 | Shifted value, registered |
| resultValid | output | 1 | One-cycle pulse one clock after start |
| illegal | output | 1 | Unrecognised encoding, pulses with resultValid |

## Verification
The assertions check the following on every cycle:
- the one-clock latency from start to valid;
- the single-cycle width of the valid pulse;
- that `illegal` never appears without valid and always comes with a zero result;
- that a zero amount passes the operand through;
- that an arithmetic shift of a negative operand keeps the top bit set.

The bench scenarios are needed for the rest. They show the bit-exact result of each shift kind in both encodings, including amount 31 and negative operands. They show that the ignored bits of `opB` and of the register fields really have no effect. They also show that each near-miss encoding is rejected, and that back-to-back starts each give their own result.

// File: rtl/bshift_pkg.sv
package bshift_pkg;
  localparam int DATA_W  = 32;
  localparam int SHAMT_W = $clog2(DATA_W);
  localparam int INSTR_W = 32;

  localparam logic [5:0] OPC_REG = 6'b010001;
  localparam logic [5:0] OPC_IMM = 6'b011001;

  localparam logic [10:0] REG_FN_LRIGHT = 11'h000;
  localparam logic [10:0] REG_FN_ARIGHT = 11'h200;
  localparam logic [10:0] REG_FN_LEFT   = 11'h400;
  localparam logic [10:0] IMM_FN_LRIGHT = 11'h000;
  localparam logic [10:0] IMM_FN_ARIGHT = 11'h010;
  localparam logic [10:0] IMM_FN_LEFT   = 11'h020;

  typedef enum logic [1:0] {
    SK_LRIGHT = 2'd0,
    SK_ARIGHT = 2'd1,
    SK_LEFT   = 2'd2
  } shiftKind_e;

  typedef struct packed {
    logic               capture;
    logic               illegal;
    shiftKind_e         kind;
    logic [SHAMT_W-1:0] amount;
  } ctrlStrobes_t;
endpackage

// File: rtl/bshift_ctrl.sv
module bshift_ctrl
  import bshift_pkg::*;
(
  input  logic               start,
  input  logic [INSTR_W-1:0] instr,
  input  logic [DATA_W-1:0]  opB,
  output ctrlStrobes_t       strobes
);
  logic [5:0]  opcode;
  logic [10:0] regFn;
  logic [10:0] immFn;
  logic        isReg;
  logic        isImm;
  logic        unusedFields;

  assign opcode = instr[INSTR_W-1 -: 6];
  assign regFn  = instr[10:0];
  assign immFn  = instr[15:5];
  assign isReg  = (opcode == OPC_REG);
  assign isImm  = (opcode == OPC_IMM);
  // Register numbers and the high operand bits carry no meaning here
  assign unusedFields = ^{instr[25:16], opB[DATA_W-1:SHAMT_W]};

  always_comb begin
    strobes.capture = start;
    strobes.illegal = 1'b0;
    strobes.kind    = SK_LRIGHT;
    strobes.amount  = '0;
    if (isReg) begin
      strobes.amount = opB[SHAMT_W-1:0];
      unique case (regFn)
        REG_FN_LRIGHT: strobes.kind = SK_LRIGHT;
        REG_FN_ARIGHT: strobes.kind = SK_ARIGHT;
        REG_FN_LEFT:   strobes.kind = SK_LEFT;
        default:       strobes.illegal = 1'b1;
      endcase
    end else if (isImm) begin
      strobes.amount = instr[SHAMT_W-1:0];
      unique case (immFn)
        IMM_FN_LRIGHT: strobes.kind = SK_LRIGHT;
        IMM_FN_ARIGHT: strobes.kind = SK_ARIGHT;
        IMM_FN_LEFT:   strobes.kind = SK_LEFT;
        default:       strobes.illegal = 1'b1;
      endcase
    end else begin
      strobes.illegal = 1'b1;
    end
  end

  // R9
  always_comb begin
    opcode_illegal_chk: assert (isReg || isImm || strobes.illegal)
      else $error("R9 unknown opcode not flagged");
  end
endmodule

// File: rtl/bshift_datapath.sv
module bshift_datapath
  import bshift_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] opA,
  output logic [DATA_W-1:0] result,
  output logic              resultValid,
  output logic              illegal
);
  logic [DATA_W-1:0] stage [0:SHAMT_W];
  logic [DATA_W-1:0] shiftIn;
  logic [DATA_W-1:0] shiftOut;
  logic              fillBit;
  logic              isLeft;

  function automatic logic [DATA_W-1:0] reverseBits(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = v[DATA_W-1-i];
    return r;
  endfunction

  assign isLeft  = (strobes.kind == SK_LEFT);
  assign fillBit = (strobes.kind == SK_ARIGHT) ? opA[DATA_W-1] : 1'b0;
  // A left shift is a right shift of the mirrored word
  assign shiftIn = isLeft ? reverseBits(opA) : opA;
  assign stage[0] = shiftIn;

  for (genvar s = 0; s < SHAMT_W; s++) begin : gStage
    localparam int STEP = 1 << s;
    assign stage[s+1] = strobes.amount[s]
                      ? {{STEP{fillBit}}, stage[s][DATA_W-1:STEP]}
                      : stage[s];
  end

  assign shiftOut = isLeft ? reverseBits(stage[SHAMT_W]) : stage[SHAMT_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result      <= '0;
      resultValid <= 1'b0;
      illegal     <= 1'b0;
    end else begin
      resultValid <= strobes.capture;
      illegal     <= strobes.capture && strobes.illegal;
      if (strobes.capture) result <= strobes.illegal ? '0 : shiftOut;
    end
  end

  // R2
  start_to_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> resultValid);
  // R2
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> !resultValid);
  // R9
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (resultValid && result == '0));
  // R8
  zero_amount_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && !strobes.illegal && strobes.amount == '0)
      |=> result == $past(opA));
  // R6
  sign_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && !strobes.illegal && strobes.kind == SK_ARIGHT && opA[DATA_W-1])
      |=> result[DATA_W-1]);
endmodule

// File: rtl/bshift_unit.sv
module bshift_unit
  import bshift_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [31:0]       instr,
  input  logic [31:0]       opA,
  input  logic [31:0]       opB,
  output logic [31:0]       result,
  output logic              resultValid,
  output logic              illegal
);
  ctrlStrobes_t strobes;

  bshift_ctrl uCtrl (
    .start   (start),
    .instr   (instr),
    .opB     (opB),
    .strobes (strobes)
  );

  bshift_datapath uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .opA         (opA),
    .result      (result),
    .resultValid (resultValid),
    .illegal     (illegal)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> (!resultValid && !illegal && result == '0));
endmodule

// File: tb/tb_bshift_unit.sv
module tb_bshift_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [31:0] result;
  logic        resultValid;
  logic        illegal;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  typedef struct {
    logic [31:0] res;
    logic        ill;
    int          due;
    string       req;
  } item_t;
  item_t sbq[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bshift_unit dut (
    .clk(clk), .rstN(rstN), .start(start), .instr(instr),
    .opA(opA), .opB(opB), .result(result),
    .resultValid(resultValid), .illegal(illegal)
  );

  // Reference model written from the requirements
  function automatic logic [32:0] model(input logic [31:0] w, input logic [31:0] a,
                                        input logic [31:0] b);
    int kind = -1;
    int amt  = 0;
    logic [31:0] o = '0;
    if (w[31:26] == 6'b010001) begin
      amt = int'(b[4:0]);
      if (w[10:0] == 11'h000) kind = 0;
      else if (w[10:0] == 11'h200) kind = 1;
      else if (w[10:0] == 11'h400) kind = 2;
    end else if (w[31:26] == 6'b011001) begin
      amt = int'(w[4:0]);
      if (w[15:5] == 11'h000) kind = 0;
      else if (w[15:5] == 11'h010) kind = 1;
      else if (w[15:5] == 11'h020) kind = 2;
    end
    if (kind < 0) return {1'b1, 32'h0};
    for (int i = 0; i < 32; i++) begin
      if (kind == 2) o[i] = (i >= amt) ? a[i-amt] : 1'b0;
      else if (i + amt < 32) o[i] = a[i+amt];
      else o[i] = (kind == 1) ? a[31] : 1'b0;
    end
    return {1'b0, o};
  endfunction

  function automatic logic [31:0] regW(input logic [10:0] fn, input logic [9:0] regs,
                                       input logic [4:0] rb);
    return {6'b010001, regs, rb, fn};
  endfunction

  function automatic logic [31:0] immW(input logic [10:0] pre, input logic [9:0] regs,
                                       input logic [4:0] amt);
    return {6'b011001, regs, pre, amt};
  endfunction

  // Driver: presents one start and pushes the expected item
  task automatic issue(input logic [31:0] w, input logic [31:0] a,
                       input logic [31:0] b, input string req);
    item_t it;
    logic [32:0] m;
    @(negedge clk);
    m = model(w, a, b);
    instr = w; opA = a; opB = b; start = 1'b1;
    it.res = m[31:0]; it.ill = m[32]; it.due = cyc + 1; it.req = req;
    sbq.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  task automatic one(input logic [31:0] w, input logic [31:0] a,
                     input logic [31:0] b, input string req);
    issue(w, a, b, req);
    idle(2);
  endtask

  // Monitor: compares outputs against the scoreboard away from the edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (sbq.size() > 0 && sbq[0].due == cyc) begin
        item_t it;
        it = sbq.pop_front();
        checks++;
        if (!resultValid || result !== it.res || illegal !== it.ill) begin
          fails++;
          $display("FAIL %s: valid=%b result=%h illegal=%b expected valid=1 result=%h illegal=%b",
                   it.req, resultValid, result, illegal, it.res, it.ill);
        end
      end else if (resultValid !== 1'b0 || illegal !== 1'b0) begin
        checks++;
        fails++;
        $display("FAIL R2: valid=%b illegal=%b expected valid=0 illegal=0",
                 resultValid, illegal);
      end
    end
  end

  task automatic finishRun();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    checks++;
    if (resultValid !== 1'b0 || illegal !== 1'b0 || result !== 32'h0) begin
      fails++;
      $display("FAIL R1: valid=%b illegal=%b result=%h expected 0 0 00000000",
               resultValid, illegal, result);
    end
    rstN = 1'b1;
    idle(2);
    // R1: still quiet after reset, before any start
    checks++;
    if (resultValid !== 1'b0 || result !== 32'h0) begin
      fails++;
      $display("FAIL R1: valid=%b result=%h expected 0 00000000", resultValid, result);
    end

    // R3/R5/R6/R7: register form
    one(regW(11'h000, 10'h000, 5'd0), 32'hF0F0_1234, 32'd4,  "R5 reg lsr");
    one(regW(11'h200, 10'h000, 5'd0), 32'h8000_00F0, 32'd4,  "R6 reg asr neg");
    one(regW(11'h200, 10'h000, 5'd0), 32'h7000_00F0, 32'd8,  "R6 reg asr pos");
    one(regW(11'h400, 10'h000, 5'd0), 32'h0000_0F0F, 32'd12, "R7 reg lsl");
    // R3: upper opB bits ignored
    one(regW(11'h400, 10'h000, 5'd0), 32'h1234_5678, 32'hFFFF_FFE3, "R3 opB high ignored");
    one(regW(11'h200, 10'h000, 5'd0), 32'hDEAD_BEEF, 32'd31, "R6 asr by 31");
    one(regW(11'h000, 10'h000, 5'd0), 32'hDEAD_BEEF, 32'd31, "R5 lsr by 31");

    // R4: immediate form, opB ignored
    one(immW(11'h000, 10'h000, 5'd7),  32'hCAFE_F00D, 32'd3, "R4 imm lsr");
    one(immW(11'h010, 10'h000, 5'd16), 32'h9ABC_DEF0, 32'd1, "R4 imm asr");
    one(immW(11'h020, 10'h000, 5'd31), 32'h0000_0003, 32'd5, "R4 imm lsl by 31");

    // R8: zero amount in every kind
    one(regW(11'h000, 10'h000, 5'd0), 32'h8765_4321, 32'h20, "R8 zero lsr");
    one(immW(11'h010, 10'h000, 5'd0), 32'h8765_4321, 32'd9,  "R8 zero asr");
    one(immW(11'h020, 10'h000, 5'd0), 32'h8765_4321, 32'd9,  "R8 zero lsl");

    // R9: near-miss encodings
    one({6'b010010, 26'h0}, 32'hFFFF_FFFF, 32'd2, "R9 bad opcode");
    one(regW(11'h600, 10'h000, 5'd0), 32'hFFFF_FFFF, 32'd2, "R9 bad reg fn");
    one(regW(11'h001, 10'h000, 5'd0), 32'hFFFF_FFFF, 32'd2, "R9 reg fn low bit");
    one(immW(11'h030, 10'h000, 5'd2), 32'hFFFF_FFFF, 32'd2, "R9 bad imm prefix");
    one(immW(11'h400, 10'h000, 5'd2), 32'hFFFF_FFFF, 32'd2, "R9 imm uses reg pattern");

    // R10: register-number fields do not matter
    one(regW(11'h200, 10'h3FF, 5'h1F), 32'hA000_0001, 32'd3, "R10 reg fields set");
    one(immW(11'h020, 10'h2A5, 5'd5),  32'h0000_00FF, 32'd0, "R10 imm fields set");

    // R2: back-to-back starts give separate results
    issue(regW(11'h000, 10'h000, 5'd0), 32'h0000_FF00, 32'd8, "R2 back-to-back a");
    issue(immW(11'h020, 10'h000, 5'd4), 32'h0000_00F1, 32'd0, "R2 back-to-back b");
    issue({6'b000000, 26'h0},           32'h1,         32'd0, "R2 back-to-back c");
    idle(6);

    checks++;
    if (sbq.size() != 0) begin
      fails++;
      $display("FAIL R2: %0d results missing, expected 0", sbq.size());
    end
    finishRun();
  end
endmodule